// File: doc/BRIEF.md
# External Memory Bus Cycle Sequencer

This block drives the external memory bus of an 8-bit microcontroller. The bus has three parts: a low port that carries both the low address byte and the data, a high address port, and four control outputs. The controls are an address latch pulse, a code-read strobe, a data-read strobe and a data-write strobe. The block counts the oscillator clock into machine cycles of twelve clocks. Each machine cycle holds two six-clock slots, and each slot normally fetches one code byte. A fetch below the internal ROM boundary stays on chip while the access strap is high. Such a fetch still pulses the address latch but raises no code-read strobe.

When the core requests a data-memory transfer, the next two machine cycles carry it. The first slot of the first cycle still fetches code. The second slot of that cycle puts out the data address. The first slot of the second cycle carries a read or write strobe that lasts twice as long as a code-read strobe. The last slot only pulses the latch. The transfer uses one of two address forms. A 16-bit address comes from the data pointer. An 8-bit address comes from the indirect register, and the high port then shows the core's own page latch.

Positions below are counted within a machine cycle from 0 to 11. Position p is the value the outputs show in the p-th clock of the cycle. Slot A covers positions 0-5 and slot B covers positions 6-11. The first clock after reset shows position 0.

Top module: `ext_bus_seq`

## Requirements
- R1: The address latch output is high for exactly one clock, at positions 0 and 6 of every cycle, whether the fetch is internal or external. The one exception is position 0 of the second transfer cycle, where it stays low.
- R2: In an external fetch slot, the low port is enabled at slot offsets 0-1 and carries the fetch address low byte; it is released for the rest of the slot. The high port carries the fetch address high byte for the whole slot.
- R3: The code-read strobe (active low) is low at slot offsets 3-5 of an external fetch slot. It is never low in an internal fetch slot or in any transfer slot.
- R4: The fetch address and strap are taken at each slot start. A fetch is internal only when the strap is high and the address is below 1000H.
- R5: The code byte on the low port is sampled on the edge where the code-read strobe rises. It is presented with a one-clock valid pulse at offset 0 of the next slot.
- R6: The transfer request is sampled at position 11 only. After acceptance, the next two cycles form the transfer. A request during the first of them is ignored, but one present at position 11 of the second is accepted and starts a new transfer at once. In the second cycle the code-read strobe never falls, and the latch pulses only at position 6, with the low port released and the page latch on the high port.
- R7: The read strobe (direction input 0) or the write strobe (direction input 1) is low for six clocks: positions 9-11 of the first transfer cycle and 0-2 of the second. The two never fall together.
- R8: For a write, the low port drives the write data from position 8 of the first transfer cycle through position 3 of the second, and is released after that. For a read, the low port stays released from position 8 through the end of the second cycle.
- R9: Read data is sampled on the edge where the read strobe rises. It is presented with a one-clock valid pulse at position 3 of the second cycle.
- R10: With the wide flag set, the data address is the data pointer. It appears as its low byte on the low port at positions 6-7 of the first cycle and as its high byte on the high port at positions 6-11 of the first cycle and 0-5 of the second. With the flag clear, the low port shows the indirect address and the high port shows the page latch. The data pointer, indirect address, direction, wide flag and write data are captured along with the request at position 11 of the preceding cycle. The page latch is used live.
- R11: In an internal fetch slot, the low port stays released and the high port shows the page latch.
- R12: In reset, the latch output and both valids are low, all strobes are high and the low port is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pc | input | 16 | Code fetch address from the core |
| dptr | input | 16 | Data pointer for wide transfers |
| ind_addr | input | 8 | Indirect address for narrow transfers |
| hi_latch | input | 8 | Core's high port latch (page bits) |
| ea | input | 1 | Access strap; high enables internal ROM |
| xfer_req | input | 1 | Data transfer request |
| xfer_wr | input | 1 | Transfer direction, 1 = write |
| xfer_wide | input | 1 | 1 = 16-bit address, 0 = 8-bit address |
| xfer_wdata | input | 8 | Write data |
| ad_in | input | 8 | Low port pad input |
| ad_out | output | 8 | Low port pad output value |
| ad_oe | output | 1 | Low port output enable |
| a_hi | output | 8 | High address port |
| ale | output | 1 | Address latch pulse, active high |
| psen_n | output | 1 | Code-read strobe, active low |
| rd_n | output | 1 | Data-read strobe, active low |
| wr_n | output | 1 | Data-write strobe, active low |
| code_byte | output | 8 | Last external code byte |
| code_valid | output | 1 | One-clock pulse with code_byte |
| rd_data | output | 8 | Last read data byte |
| rd_valid | output | 1 | One-clock pulse with rd_data |

## Verification
The bench builds the default configuration: six states per machine cycle, a three-clock code strobe, two clocks of address hold and a 4 KiB internal boundary. With this small setup, every clock of every cycle can be compared with a position-based expectation. The fetch sweep covers both strap values and addresses on each side of the boundary (0000H, 0FFFH, 1000H, FFFFH and two interior values). It is followed by all four combinations of direction and address width, each under both internal and external fetch. A back-to-back pair, with the request held through the busy cycle, exercises the acceptance points.

// File: rtl/ebs_pkg.sv
// Shared types for the external bus sequencer.
// Assumes an 8-bit data path and a 16-bit address made of two bytes.
package ebs_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 2 * BYTE_W;

    // Transfer progress, advanced once per machine cycle
    typedef enum logic [1:0] {
        XS_IDLE = 2'd0,
        XS_ADDR = 2'd1,   // first cycle: fetch in slot A, data address in slot B
        XS_DATA = 2'd2    // second cycle: strobe in slot A, latch-only slot B
    } xfer_st_t;

    // Transfer fields frozen at acceptance
    typedef struct packed {
        logic              wr;
        logic              wide;
        logic [BYTE_W-1:0] lo_addr;
        logic [BYTE_W-1:0] dhi;
        logic [BYTE_W-1:0] wdata;
    } xfer_cap_t;
endpackage

// File: rtl/ebs_phase.sv
// Machine cycle position counter and per-slot fetch address holder.
// Assumes the core keeps pc and ea valid on the clock that starts a slot;
// both are then held internally for the rest of the slot.
module ebs_phase
    import ebs_pkg::*;
#(
    parameter int STATES       = 6,
    parameter int INT_ROM_BITS = 12,
    parameter int PH_W         = $clog2(2 * STATES),
    parameter int K_W          = $clog2(STATES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] pc,
    input  logic              ea,
    output logic [PH_W-1:0]   ph,
    output logic              slot_b,
    output logic [K_W-1:0]    pos,
    output logic              cyc_end,
    output logic [ADDR_W-1:0] fetch_pc,
    output logic              fetch_ext
);
    localparam int CYC = 2 * STATES;

    logic [ADDR_W-1:0] pc_q;
    logic              ext_q;
    logic              slot_start;
    logic              ext_live;

    // Position counter, wraps every machine cycle
    always_ff @(posedge clk) begin
        if (!rst_n)             ph <= '0;
        else if (cyc_end)       ph <= '0;
        else                    ph <= ph + 1'b1;
    end

    // Split the cycle into two slots and an offset within the slot
    always_comb begin
        cyc_end    = (ph == PH_W'(CYC - 1));
        slot_b     = (ph >= PH_W'(STATES));
        pos        = slot_b ? K_W'(ph - PH_W'(STATES)) : K_W'(ph);
        slot_start = (pos == '0);
        ext_live   = !ea || (pc[ADDR_W-1:INT_ROM_BITS] != '0);
        fetch_pc   = slot_start ? pc : pc_q;
        fetch_ext  = slot_start ? ext_live : ext_q;
    end

    // Hold the slot's fetch address and placement after its first clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q  <= '0;
            ext_q <= 1'b0;
        end else begin
            pc_q  <= fetch_pc;
            ext_q <= fetch_ext;
        end
    end

    // R1
    cyc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_W'(CYC - 1)) |=> (ph == '0));
    // R1
    cyc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ph != PH_W'(CYC - 1)) |=> (ph == $past(ph) + 1'b1));
endmodule

// File: rtl/ebs_xfer.sv
// Data transfer tracker: accepts a request at a machine cycle end and
// walks it through its two cycles, freezing the transfer fields.
// Assumes request fields are valid on the last clock of the cycle.
module ebs_xfer
    import ebs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_end,
    input  logic              req,
    input  logic              wr,
    input  logic              wide,
    input  logic [ADDR_W-1:0] dptr,
    input  logic [BYTE_W-1:0] ind_addr,
    input  logic [BYTE_W-1:0] wdata,
    output xfer_st_t          xs,
    output xfer_cap_t         cap
);
    // Advance once per machine cycle; a request is taken only when not mid-transfer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xs  <= XS_IDLE;
            cap <= '0;
        end else if (cyc_end) begin
            case (xs)
                XS_ADDR: xs <= XS_DATA;
                default: begin
                    if (req) begin
                        xs          <= XS_ADDR;
                        cap.wr      <= wr;
                        cap.wide    <= wide;
                        cap.lo_addr <= wide ? dptr[BYTE_W-1:0] : ind_addr;
                        cap.dhi     <= dptr[ADDR_W-1:BYTE_W];
                        cap.wdata   <= wdata;
                    end else begin
                        xs <= XS_IDLE;
                    end
                end
            endcase
        end
    end

    // R6
    xs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_end |=> $stable(xs));
    // R6
    xs_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xs == XS_ADDR && cyc_end) |=> (xs == XS_DATA));
endmodule

// File: rtl/ebs_drive.sv
// Pin decoder and output registers. Decodes the slot position, fetch
// placement and transfer phase into the next pin values and registers
// them, so every pin changes only at a clock edge. Samples the low port
// on the edge where a read-type strobe rises.
module ebs_drive
    import ebs_pkg::*;
#(
    parameter int STATES    = 6,
    parameter int PSEN_LEN  = 3,
    parameter int ADDR_HOLD = 2,
    parameter int K_W       = $clog2(STATES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_b,
    input  logic [K_W-1:0]    pos,
    input  logic [ADDR_W-1:0] fetch_pc,
    input  logic              fetch_ext,
    input  xfer_st_t          xs,
    input  xfer_cap_t         cap,
    input  logic [BYTE_W-1:0] hi_latch,
    input  logic [BYTE_W-1:0] ad_in,
    output logic              ale,
    output logic              psen_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic              ad_oe,
    output logic [BYTE_W-1:0] ad_out,
    output logic [BYTE_W-1:0] a_hi,
    output logic [BYTE_W-1:0] code_byte,
    output logic              code_valid,
    output logic [BYTE_W-1:0] rd_data,
    output logic              rd_valid
);
    localparam int STROBE_AT = STATES - PSEN_LEN;

    logic              n_ale, n_psen, n_rd, n_wr, n_oe;
    logic [BYTE_W-1:0] n_ado, n_ahi;
    logic              data_a, data_b, idle_b;
    logic [BYTE_W-1:0] xfer_hi;
    int                k;

    // Next pin values from slot position and transfer phase
    always_comb begin
        k       = int'(pos);
        data_a  = (xs == XS_ADDR) && slot_b;
        data_b  = (xs == XS_DATA) && !slot_b;
        idle_b  = (xs == XS_DATA) && slot_b;
        xfer_hi = cap.wide ? cap.dhi : hi_latch;
        n_ale   = 1'b0;
        n_psen  = 1'b1;
        n_rd    = 1'b1;
        n_wr    = 1'b1;
        n_oe    = 1'b0;
        n_ado   = ad_out;
        n_ahi   = hi_latch;
        if (data_a) begin
            n_ale = (k == 0);
            n_ahi = xfer_hi;
            if (k < ADDR_HOLD) begin
                n_oe  = 1'b1;
                n_ado = cap.lo_addr;
            end else if (cap.wr) begin
                n_oe  = 1'b1;
                n_ado = cap.wdata;
            end
            if (k >= STROBE_AT) begin
                n_rd = cap.wr;
                n_wr = !cap.wr;
            end
        end else if (data_b) begin
            n_ahi = xfer_hi;
            if (k < PSEN_LEN) begin
                n_rd = cap.wr;
                n_wr = !cap.wr;
            end
            if (cap.wr && k <= PSEN_LEN) begin
                n_oe  = 1'b1;
                n_ado = cap.wdata;
            end
        end else if (idle_b) begin
            n_ale = (k == 0);
        end else begin
            n_ale = (k == 0);
            if (fetch_ext) begin
                n_ahi = fetch_pc[ADDR_W-1:BYTE_W];
                if (k < ADDR_HOLD) begin
                    n_oe  = 1'b1;
                    n_ado = fetch_pc[BYTE_W-1:0];
                end
                n_psen = !(k >= STROBE_AT);
            end
        end
    end

    // Register the pins and capture returning bytes at strobe release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ale        <= 1'b0;
            psen_n     <= 1'b1;
            rd_n       <= 1'b1;
            wr_n       <= 1'b1;
            ad_oe      <= 1'b0;
            ad_out     <= '0;
            a_hi       <= '0;
            code_byte  <= '0;
            code_valid <= 1'b0;
            rd_data    <= '0;
            rd_valid   <= 1'b0;
        end else begin
            ale        <= n_ale;
            psen_n     <= n_psen;
            rd_n       <= n_rd;
            wr_n       <= n_wr;
            ad_oe      <= n_oe;
            ad_out     <= n_ado;
            a_hi       <= n_ahi;
            code_valid <= !psen_n && n_psen;
            rd_valid   <= !rd_n && n_rd;
            if (!psen_n && n_psen) code_byte <= ad_in;
            if (!rd_n && n_rd)     rd_data   <= ad_in;
        end
    end

    // R3
    psen_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!psen_n && !(rd_n && wr_n)));
    // R7
    rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));
    // R8
    wr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> ad_oe);
    // R8
    rd_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);
    // R2
    psen_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !psen_n |-> !ad_oe);
    // R1
    ale_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (psen_n && rd_n && wr_n));
    // R5
    code_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid |-> $rose(psen_n));
    // R9
    rd_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $rose(rd_n));
endmodule

// File: rtl/ext_bus_seq.sv
// External memory bus cycle sequencer top. Connects the position counter,
// the transfer tracker and the pin decoder.
// Assumes one clock per oscillator period and a synchronous active-low reset.
module ext_bus_seq
    import ebs_pkg::*;
#(
    parameter int STATES       = 6,
    parameter int PSEN_LEN     = 3,
    parameter int ADDR_HOLD    = 2,
    parameter int INT_ROM_BITS = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] dptr,
    input  logic [BYTE_W-1:0] ind_addr,
    input  logic [BYTE_W-1:0] hi_latch,
    input  logic              ea,
    input  logic              xfer_req,
    input  logic              xfer_wr,
    input  logic              xfer_wide,
    input  logic [BYTE_W-1:0] xfer_wdata,
    input  logic [BYTE_W-1:0] ad_in,
    output logic [BYTE_W-1:0] ad_out,
    output logic              ad_oe,
    output logic [BYTE_W-1:0] a_hi,
    output logic              ale,
    output logic              psen_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic [BYTE_W-1:0] code_byte,
    output logic              code_valid,
    output logic [BYTE_W-1:0] rd_data,
    output logic              rd_valid
);
    localparam int PH_W = $clog2(2 * STATES);
    localparam int K_W  = $clog2(STATES);

    logic [PH_W-1:0]   ph;
    logic              slot_b;
    logic [K_W-1:0]    pos;
    logic              cyc_end;
    logic [ADDR_W-1:0] fetch_pc;
    logic              fetch_ext;
    xfer_st_t          xs;
    xfer_cap_t         cap;

    ebs_phase #(
        .STATES(STATES), .INT_ROM_BITS(INT_ROM_BITS), .PH_W(PH_W), .K_W(K_W)
    ) u_phase (
        .clk(clk), .rst_n(rst_n), .pc(pc), .ea(ea),
        .ph(ph), .slot_b(slot_b), .pos(pos), .cyc_end(cyc_end),
        .fetch_pc(fetch_pc), .fetch_ext(fetch_ext)
    );

    ebs_xfer u_xfer (
        .clk(clk), .rst_n(rst_n), .cyc_end(cyc_end), .req(xfer_req),
        .wr(xfer_wr), .wide(xfer_wide), .dptr(dptr), .ind_addr(ind_addr),
        .wdata(xfer_wdata), .xs(xs), .cap(cap)
    );

    ebs_drive #(
        .STATES(STATES), .PSEN_LEN(PSEN_LEN), .ADDR_HOLD(ADDR_HOLD), .K_W(K_W)
    ) u_drive (
        .clk(clk), .rst_n(rst_n), .slot_b(slot_b), .pos(pos),
        .fetch_pc(fetch_pc), .fetch_ext(fetch_ext), .xs(xs), .cap(cap),
        .hi_latch(hi_latch), .ad_in(ad_in),
        .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
        .ad_oe(ad_oe), .ad_out(ad_out), .a_hi(a_hi),
        .code_byte(code_byte), .code_valid(code_valid),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );
endmodule

// File: tb/ext_bus_seq_tb.sv
// Clock-by-clock bench: every output is compared each clock against a
// position-based expectation derived from the requirements.
module ext_bus_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pc = '0, dptr = '0;
    logic [7:0]  ind_addr = '0, hi_latch = 8'hC3, xfer_wdata = '0;
    logic        ea = 1'b1, xfer_req = 1'b0, xfer_wr = 1'b0, xfer_wide = 1'b0;
    logic [7:0]  ad_in, ad_out, a_hi, code_byte, rd_data;
    logic        ad_oe, ale, psen_n, rd_n, wr_n, code_valid, rd_valid;
    logic [7:0]  bus_v = 8'h21;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    // expectation state
    logic [15:0] cur_pc = '0;
    bit          cur_ea = 1;
    bit          x_wr, x_wide;
    logic [15:0] x_dptr;
    logic [7:0]  x_ri, x_wd;
    bit          prev_fetch = 0;
    logic [7:0]  prev_bus = '0;
    logic [7:0]  rd_exp = '0;

    assign ad_in = ad_oe ? ad_out : bus_v;

    always #5 clk = ~clk;

    ext_bus_seq u_dut (
        .clk(clk), .rst_n(rst_n), .pc(pc), .dptr(dptr), .ind_addr(ind_addr),
        .hi_latch(hi_latch), .ea(ea), .xfer_req(xfer_req), .xfer_wr(xfer_wr),
        .xfer_wide(xfer_wide), .xfer_wdata(xfer_wdata), .ad_in(ad_in),
        .ad_out(ad_out), .ad_oe(ad_oe), .a_hi(a_hi), .ale(ale), .psen_n(psen_n),
        .rd_n(rd_n), .wr_n(wr_n), .code_byte(code_byte), .code_valid(code_valid),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    task automatic chk(input string req, input int q, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s pos=%0d actual=%0h expected=%0h", req, q, act, exp);
        end
    endtask

    // kind: 0 plain fetch cycle, 1 first transfer cycle, 2 second transfer cycle
    task automatic check_pos(input int q, input int kind);
        bit sb = (q >= 6);
        int k = q % 6;
        bit ext = !cur_ea || (cur_pc >= 16'h1000);
        bit fetch = (kind == 0) || (kind == 1 && !sb);
        bit e_ale = 0, e_psen = 1, e_rd = 1, e_wr = 1, e_oe = 0;
        logic [7:0] e_ado = '0;
        logic [7:0] e_ahi = hi_latch;
        logic [7:0] xhi = x_wide ? x_dptr[15:8] : hi_latch;
        logic [7:0] xlo = x_wide ? x_dptr[7:0] : x_ri;
        if (fetch) begin
            e_ale = (k == 0);
            if (ext) begin
                e_ahi = cur_pc[15:8];
                if (k <= 1) begin e_oe = 1; e_ado = cur_pc[7:0]; end
                e_psen = !(k >= 3);
            end
        end else if (kind == 1) begin
            e_ale = (k == 0);
            e_ahi = xhi;
            if (k <= 1) begin e_oe = 1; e_ado = xlo; end
            else if (x_wr) begin e_oe = 1; e_ado = x_wd; end
            if (k >= 3) begin e_rd = x_wr; e_wr = !x_wr; end
        end else if (!sb) begin
            e_ahi = xhi;
            if (k <= 2) begin e_rd = x_wr; e_wr = !x_wr; end
            if (x_wr && k <= 3) begin e_oe = 1; e_ado = x_wd; end
        end else begin
            e_ale = (k == 0);
        end
        chk("R1 ale", q, ale, e_ale);
        chk("R3 psen_n", q, psen_n, e_psen);
        chk("R7 rd_n", q, rd_n, e_rd);
        chk("R7 wr_n", q, wr_n, e_wr);
        chk(kind == 0 ? (ext ? "R2 ad_oe" : "R11 ad_oe") : "R8 ad_oe", q, ad_oe, e_oe);
        if (e_oe) chk(kind == 0 ? "R2 ad_out" : "R10 ad_out", q, ad_out, e_ado);
        chk(kind == 0 ? (ext ? "R4 a_hi" : "R11 a_hi") : "R10 a_hi", q, a_hi, e_ahi);
        if (k == 0) begin
            chk("R5 code_valid", q, code_valid, prev_fetch);
            if (prev_fetch) chk("R5 code_byte", q, code_byte, prev_bus);
        end else begin
            chk("R5 code_valid", q, code_valid, 0);
        end
        chk("R9 rd_valid", q, rd_valid, (kind == 2 && q == 3 && !x_wr));
        if (kind == 2 && q == 3 && !x_wr) chk("R9 rd_data", q, rd_data, rd_exp);
        if (kind == 2 && q == 2) rd_exp = bus_v;
        if (k == 5) begin
            prev_fetch = fetch && ext;
            prev_bus   = bus_v;
        end
    endtask

    task automatic run_cycle(input int kind);
        for (int i = 0; i < 12; i++) begin
            @(posedge clk);
            @(negedge clk);
            check_pos(i, kind);
            if (i == 1 || i == 7) bus_v = bus_v * 8'd5 + 8'h3B;
        end
    endtask

    task automatic set_fetch(input logic [15:0] a, input bit strap);
        pc = a; ea = strap; cur_pc = a; cur_ea = strap;
    endtask

    task automatic set_req(input bit wr, input bit wide, input logic [15:0] dp,
                           input logic [7:0] ri, input logic [7:0] wd);
        xfer_wr = wr; xfer_wide = wide; dptr = dp; ind_addr = ri; xfer_wdata = wd;
    endtask

    task automatic take_req();
        x_wr = xfer_wr; x_wide = xfer_wide; x_dptr = dptr; x_ri = ind_addr; x_wd = xfer_wdata;
    endtask

    // watchdog
    initial begin
        #1000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] addrs [6] = '{16'h0000, 16'h0FFF, 16'h1000, 16'hFFFF, 16'h0ABC, 16'h2345};
        // R12: reset state
        repeat (3) @(negedge clk);
        chk("R12 ale", -1, ale, 0);
        chk("R12 psen_n", -1, psen_n, 1);
        chk("R12 rd_n", -1, rd_n, 1);
        chk("R12 wr_n", -1, wr_n, 1);
        chk("R12 ad_oe", -1, ad_oe, 0);
        chk("R12 code_valid", -1, code_valid, 0);
        chk("R12 rd_valid", -1, rd_valid, 0);
        set_fetch(16'h0000, 1);
        rst_n = 1'b1;

        // R4: fetch sweep over strap and boundary addresses
        for (int s = 0; s < 2; s++) begin
            for (int a = 0; a < 6; a++) begin
                set_fetch(addrs[a], s[0]);
                run_cycle(0);
            end
        end

        // R6 R7 R8 R9 R10: all direction and width combinations
        for (int e = 0; e < 2; e++) begin
            for (int c = 0; c < 4; c++) begin
                set_fetch(e == 0 ? 16'h0100 : 16'h2345, e == 0);
                set_req(c[0], c[1], 16'h5A00 + 16'(c * 16'h0111), 8'h30 + 8'(c), 8'h90 + 8'(c * 7));
                xfer_req = 1'b1;
                run_cycle(0);
                take_req();
                xfer_req = 1'b0;
                run_cycle(1);
                run_cycle(2);
            end
        end

        // R6: request held through the busy cycle, then accepted back to back
        set_fetch(16'h3456, 0);
        set_req(1, 1, 16'hBEEF, 8'h11, 8'hA5);
        xfer_req = 1'b1;
        run_cycle(0);
        take_req();
        run_cycle(1);
        run_cycle(2);
        take_req();
        xfer_req = 1'b0;
        set_req(0, 0, 16'h0000, 8'h77, 8'h00);
        run_cycle(1);
        run_cycle(2);
        set_fetch(16'h0040, 1);
        run_cycle(0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule